// File: doc/BRIEF.md
# Eight-Line Interrupt Pending Controller

This block collects eight peripheral interrupt request lines into one byte of pending flags. Each line owns one bit, whose code is its one-hot value: line 0 is 0x01, line 1 is 0x02, and so on up to line 7 at 0x80. A flag is set only on a rising edge of its line. A source that stays high after its flag has been serviced therefore cannot raise the flag again. An enable mask byte is ANDed with the pending byte to form the active set. A single registered interrupt output to the CPU is high whenever the active set is nonzero.

The CPU reaches the block through a plain register bus with a byte address, a 32-bit write data word, a write strobe and a combinational read data word. Software services a source by writing that source's one-hot code, as a little-endian 32-bit word, to an acknowledge register. It then reads the pending byte and repeats the write until the bit reads back as zero. The bus has no handshake: every write strobe is taken in the cycle it appears, and reads return data in the same cycle. No pin carries streaming data, so there is no valid/ready interface and no back-pressure.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A rising edge on source line i (low in the previous cycle, high now) sets pending bit i, which has code 1<<i. The pending byte reads back in bits 7:0 at byte offset 0x18, and the upper read bits are zero.
- R2: A source held high, or a falling edge, never sets a pending bit. A bit that was acknowledged while its line stayed high stays clear.
- R3: A write to offset 0x10 clears every pending bit named by bits 7:0 of the write data. Several bits may be cleared in one write. Pending bits not named keep their value, and write data bits 31:8 are ignored.
- R4: If a rising edge on a line arrives in the same cycle as an acknowledge of that line, the edge wins and the bit stays set.
- R5: The enable mask is written and read at offset 0x18 minus 4, that is 0x14, in bits 7:0.
- R6: cpu_irq_o is a register. In each cycle it equals the OR of (pending AND mask) as it stood in the previous cycle, so the output follows a new pending bit by one clock.
- R7: While reset is asserted, the pending byte reads 0x00, the mask reads 0x00 and cpu_irq_o is low. The line history is also cleared.
- R8: Writes to the pending offset or to unmapped offsets change no state. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 8 | Interrupt request lines, synchronous to clk_i |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data word |
| bus_we_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| cpu_irq_o | output | 1 | Registered interrupt request to the CPU |

## Verification
A wrong pending flag shows on the read port at offset 0x18 one clock after the edge or acknowledge that caused it. One more clock later it shows on cpu_irq_o, unless the mask hides it. A lost edge history would make a held line re-raise its bit after an acknowledge. That fault becomes visible on the very next read of the pending byte. A fault in acknowledge decoding shows either as a bit that never drops, which is how polling software would hang, or as a neighbouring bit that vanishes. Both show within one cycle of the acknowledge write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQC_LINES  = 8;
  localparam int unsigned IRQC_ADDR_W = 8;
  localparam int unsigned IRQC_DATA_W = 32;
  // register byte offsets; the pending offset is fixed by the software contract
  localparam int unsigned OFS_ACK  = 32'h10;
  localparam int unsigned OFS_MASK = 32'h14;
  localparam int unsigned OFS_PEND = 32'h18;
endpackage

// File: rtl/irqc_rise_detect.sv
module irqc_rise_detect #(
  parameter int unsigned N = irqc_pkg::IRQC_LINES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic hist_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= 1'b0;
      else         hist_q <= line_i[g];
    end
    assign rise_o[g] = line_i[g] & ~hist_q;
  end
endmodule

// File: rtl/irqc_pending_bank.sv
module irqc_pending_bank #(
  parameter int unsigned N = irqc_pkg::IRQC_LINES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic flag_q;
    // set has priority over clear: a fresh edge survives its own acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (rise_i[g]) flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign pend_o[g] = flag_q;
  end
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif #(
  parameter int unsigned N      = irqc_pkg::IRQC_LINES,
  parameter int unsigned ADDR_W = irqc_pkg::IRQC_ADDR_W,
  parameter int unsigned DATA_W = irqc_pkg::IRQC_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      ack_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - N;
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(irqc_pkg::OFS_ACK);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(irqc_pkg::OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(irqc_pkg::OFS_PEND);

  logic         hit_ack, hit_mask;
  logic [N-1:0] mask_q;
  logic         unused_wdata_hi;

  assign hit_ack   = we_i && (addr_i == A_ACK);
  assign hit_mask  = we_i && (addr_i == A_MASK);
  assign ack_clr_o = hit_ack ? wdata_i[N-1:0] : '0;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (hit_mask) mask_q <= wdata_i[N-1:0];
  end
  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_PEND)      rdata_o = {{PAD_W{1'b0}}, pend_i};
    else if (addr_i == A_MASK) rdata_o = {{PAD_W{1'b0}}, mask_q};
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int unsigned NUM_SRC = irqc_pkg::IRQC_LINES,
  parameter int unsigned ADDR_W  = irqc_pkg::IRQC_ADDR_W,
  parameter int unsigned DATA_W  = irqc_pkg::IRQC_DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic               bus_we_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               cpu_irq_o
);
  logic [NUM_SRC-1:0] rise_vec, ack_clr, pend, mask;
  logic               irq_q;

  irqc_rise_detect #(.N(NUM_SRC)) u_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(irq_src_i), .rise_o(rise_vec)
  );

  irqc_pending_bank #(.N(NUM_SRC)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise_vec), .clr_i(ack_clr), .pend_o(pend)
  );

  irqc_regif #(.N(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .we_i(bus_we_i), .pend_i(pend), .mask_o(mask), .ack_clr_o(ack_clr),
    .rdata_o(bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend & mask);
  end
  assign cpu_irq_o = irq_q;
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int unsigned N = irqc_pkg::IRQC_LINES
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] rise_vec,
  input logic [N-1:0] ack_clr,
  input logic [N-1:0] pend,
  input logic [N-1:0] mask,
  input logic         irq
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((pend & $past(rise_vec)) == $past(rise_vec)));  // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((pend & ~$past(pend) & ~$past(rise_vec)) == '0));  // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((pend & $past(ack_clr) & ~$past(rise_vec)) == '0));  // R3
  AST_ACK_KEEPS_OTHERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (($past(pend) & ~$past(ack_clr) & ~pend) == '0));  // R3
  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (irq == $past(|(pend & mask))));  // R6
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.N(NUM_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rise_vec(rise_vec), .ack_clr(ack_clr),
  .pend(pend), .mask(mask), .irq(cpu_irq_o)
);

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
  localparam logic [7:0] A_ACK = 8'h10, A_MASK = 8'h14, A_PEND = 8'h18;
  localparam int NV = 12;
  // fields: {src, ack, mask, expected pending, expected irq}
  localparam logic [39:0] VEC [NV] = '{
    {8'h01, 8'h00, 8'hFF, 8'h01, 8'h01},  // R1 rise sets
    {8'h01, 8'h01, 8'hFF, 8'h00, 8'h00},  // R2 held line acked
    {8'h01, 8'h00, 8'hFF, 8'h00, 8'h00},  // R2 stays clear
    {8'h83, 8'h00, 8'h00, 8'h82, 8'h00},  // R6 masked
    {8'h83, 8'h00, 8'h02, 8'h82, 8'h01},  // R6 unmasked
    {8'h00, 8'h82, 8'h02, 8'h00, 8'h00},  // R3 multi clear
    {8'h10, 8'h00, 8'h10, 8'h10, 8'h01},  // R1
    {8'h00, 8'h00, 8'h10, 8'h10, 8'h01},  // R2 falling edge
    {8'h10, 8'h10, 8'h10, 8'h10, 8'h01},  // R4 edge beats ack
    {8'h10, 8'h10, 8'h10, 8'h00, 8'h00},  // R3
    {8'hFF, 8'h00, 8'hFF, 8'hEF, 8'h01},  // R1 R2 mixed
    {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_pend_ctrl u_irq_pend_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_we_i(we), .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); we = 1'b0; addr = a;
    #1 check(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R7 reset state
    repeat (3) @(negedge clk);
    addr = A_PEND; #1 check("R7 pending", rdata, 32'h0);
    check("R7 irq", {31'b0, irq}, 32'h0);
    addr = A_MASK; #1 check("R7 mask", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); addr = A_MASK; wdata = {24'h0, VEC[i][23:16]}; we = 1'b1;
      @(negedge clk); src = VEC[i][39:32];
      if (VEC[i][31:24] != 8'h00) begin addr = A_ACK; wdata = {24'h0, VEC[i][31:24]}; we = 1'b1; end
      else we = 1'b0;
      @(negedge clk); we = 1'b0; addr = A_PEND;
      @(negedge clk);
      #1 check($sformatf("R1/R2/R3/R4 pending vec %0d", i), rdata, {24'h0, VEC[i][15:8]});
      check($sformatf("R6 irq vec %0d", i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end

    // R5 mask readback
    wr(A_MASK, 32'hA5);
    rd_check("R5 mask readback", A_MASK, 32'hA5);

    // R8 write to pending and unmapped offsets ignored, unmapped read zero
    @(negedge clk); src = 8'h04;
    rd_check("R1 line 2 set", A_PEND, 32'h04);
    wr(A_PEND, 32'h0000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd_check("R8 pending unchanged", A_PEND, 32'h04);
    rd_check("R8 mask unchanged", A_MASK, 32'hA5);
    rd_check("R8 unmapped read", 8'h00, 32'h0);

    // R3 ack of a non-pending bit leaves others, upper data bits ignored
    wr(A_ACK, 32'hFFFF_FF01);
    rd_check("R3 other bit kept", A_PEND, 32'h04);
    wr(A_ACK, 32'h0000_0004);
    rd_check("R3 single clear", A_PEND, 32'h0);
    @(negedge clk); src = 8'h00;

    // R6 registered one-cycle lag
    wr(A_MASK, 32'hFF);
    @(negedge clk); src = 8'h20; addr = A_PEND;
    @(negedge clk);
    #1 check("R6 pending visible", rdata, 32'h20);
    check("R6 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    #1 check("R6 irq follows", {31'b0, irq}, 32'h1);
    wr(A_ACK, 32'h20);
    @(negedge clk);
    #1 check("R2 held after ack", rdata, 32'h0);
    check("R6 irq drops", {31'b0, irq}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule